// File: doc/BRIEF.md
# Receive FIFO Flow-Control Trigger

This block sits beside a receive FIFO and decides when the link partner should be asked to stop sending. It compares the FIFO's current byte occupancy against a byte trigger level, and its own count of complete frames held in the FIFO against a frame trigger level. When either level is reached, it raises a registered pause-request level for the PAUSE frame generator. The request falls only after both quantities have dropped below their levels.

Each trigger level is selected by a 3-bit code. The byte level is `(code+1)*256 - 32`, which spans 224 to 2016 bytes. The frame level is `(code+1)*2`, which spans 2 to 16 frames. The block keeps the stored-frame count from a pair of strobes, one for a frame stored and one for a frame removed. It also records receive FIFO overflow events in a sticky flag and a saturating event counter.

The codes are sampled only while no pause is being requested. A request in progress therefore always ends against the levels that started it.

Top module: `rxq_pause_trigger`

## Requirements
- R1: After reset, `pause_req`, `ovf_seen` and `ovf_events` are 0, `frames_held` is 0, and both latched threshold codes are 0.
- R2: `pause_req` is 1 in the cycle after a clock edge at which `fifo_bytes >= (C+1)*256 - 32`, where C is the latched byte code. For example, code 0 triggers at 224 and code 7 triggers at 2016.
- R3: `pause_req` is 1 in the cycle after a clock edge at which `frames_held >= (F+1)*2`, where F is the latched frame code.
- R4: `pause_req` is 0 in the cycle after an edge at which both the byte condition and the frame condition are false.
- R5: At each edge, `frames_held` behaves as follows:
  - it increases by 1 when only `frame_in` is high;
  - it decreases by 1 when only `frame_out` is high;
  - it is unchanged when both strobes are high or both are low.
- R6: `frames_held` never wraps. A lone `frame_out` at 0 leaves it at 0, and a lone `frame_in` at the all-ones value leaves it there.
- R7: The threshold codes are latched at every edge at which `pause_req` is 0. A code change while `pause_req` is 1 has no effect until the request has dropped.
- R8: An `ovf_hit` pulse sets `ovf_seen` at the next edge, and `ovf_seen` then stays 1 until reset.
- R9: `ovf_events` increases by 1 per edge with `ovf_hit` high and holds at its all-ones value (255 with defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_code | input | 3 | Byte trigger code |
| frame_code | input | 3 | Frame trigger code |
| fifo_bytes | input | 12 | Current receive FIFO byte occupancy |
| frame_in | input | 1 | One complete frame was stored this cycle |
| frame_out | input | 1 | One frame was removed this cycle |
| ovf_hit | input | 1 | Receive FIFO overflow event this cycle |
| pause_req | output | 1 | Registered pause request level |
| frames_held | output | 5 | Tracked count of frames in the FIFO |
| ovf_seen | output | 1 | Sticky overflow flag |
| ovf_events | output | 8 | Saturating overflow event count |

## Verification
Every output is due one clock after the edge that samples its cause.
- `frames_held`, `ovf_seen` and `ovf_events` follow the strobes at that edge.
- `pause_req` reflects the byte occupancy and the frame count as they stood at that edge. A `frame_in` that completes a trigger level therefore shows on `pause_req` two edges after the strobe.

The bench drives inputs on the falling edge and waits for one rising edge. It then advances its reference model with the inputs and state of that edge and compares at the following falling edge. The directed cases sit exactly on the 223/224, 2015/2016 and frame-level boundaries, and on the code-change-during-pause case.

// File: rtl/rxq_pause_pkg.sv
package rxq_pause_pkg;
   localparam int unsigned CODE_W      = 3;
   localparam int unsigned BYTE_STEP   = 256;
   localparam int unsigned BYTE_OFFSET = 32;
   localparam int unsigned FRAME_STEP  = 2;
   localparam int unsigned NUM_CODES   = 1 << CODE_W;

   typedef struct packed {
      logic [CODE_W-1:0] byte_c;
      logic [CODE_W-1:0] frame_c;
   } thr_codes_t;
endpackage

// File: rtl/rxq_level_decode.sv
module rxq_level_decode #(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned LVL_W  = 12,
   parameter int unsigned STEP   = 256,
   parameter int unsigned OFFSET = 0
) (
   input  logic [CODE_W-1:0] code,
   output logic [LVL_W-1:0]  level
);
   localparam int unsigned MAX_LVL = (1 << CODE_W) * STEP;
   localparam bit POW2 = ((STEP & (STEP - 1)) == 0);

   if (MAX_LVL >= (1 << LVL_W)) begin : g_bad_width
      $error("rxq_level_decode: LVL_W too narrow for STEP");
   end
   if (OFFSET >= STEP) begin : g_bad_offset
      $error("rxq_level_decode: OFFSET must be below STEP");
   end

   logic [LVL_W-1:0] mult;
   if (POW2) begin : g_shift
      localparam int unsigned SH = $clog2(STEP);
      assign mult = (LVL_W'(code) + LVL_W'(1)) << SH;
   end else begin : g_mul
      assign mult = (LVL_W'(code) + LVL_W'(1)) * LVL_W'(STEP);
   end
   assign level = mult - LVL_W'(OFFSET);
endmodule

// File: rtl/rxq_frame_tally.sv
module rxq_frame_tally #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (inc && !dec && cnt != TOP) cnt <= cnt + W'(1);
      else if (dec && !inc && cnt != '0)  cnt <= cnt - W'(1);
   end

   p_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt != TOP) |=> cnt == $past(cnt) + W'(1));
   p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - W'(1));
   p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(cnt));
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && dec && !inc) |=> cnt == '0);
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP && inc && !dec) |=> cnt == TOP);
endmodule

// File: rtl/rxq_ovf_tracker.sv
module rxq_ovf_tracker #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   output logic         seen,
   output logic [W-1:0] events
);
   localparam logic [W-1:0] SAT = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= 1'b0;
         events <= '0;
      end else if (hit) begin
         seen <= 1'b1;
         if (events != SAT) events <= events + W'(1);
      end
   end

   p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> seen);
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seen |=> seen);
   p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      events == SAT |=> events == SAT);
   p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && events != SAT) |=> events == $past(events) + W'(1));
endmodule

// File: rtl/rxq_pause_trigger.sv
module rxq_pause_trigger
   import rxq_pause_pkg::*;
#(
   parameter int unsigned BYTE_W  = 12,
   parameter int unsigned FRAME_W = 5,
   parameter int unsigned OVF_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  byte_code,
   input  logic [CODE_W-1:0]  frame_code,
   input  logic [BYTE_W-1:0]  fifo_bytes,
   input  logic               frame_in,
   input  logic               frame_out,
   input  logic               ovf_hit,
   output logic               pause_req,
   output logic [FRAME_W-1:0] frames_held,
   output logic               ovf_seen,
   output logic [OVF_W-1:0]   ovf_events
);
   localparam int unsigned MAX_FRAMES = NUM_CODES * FRAME_STEP;

   if (MAX_FRAMES >= (1 << FRAME_W)) begin : g_bad_frame_w
      $error("rxq_pause_trigger: FRAME_W cannot hold the top frame level");
   end
   if (OVF_W < 1) begin : g_bad_ovf_w
      $error("rxq_pause_trigger: OVF_W must be positive");
   end

   thr_codes_t        held;
   logic [BYTE_W-1:0]  byte_lvl;
   logic [FRAME_W-1:0] frame_lvl;
   logic               byte_hit, frame_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held <= '0;
      else if (!pause_req) held <= '{byte_c: byte_code, frame_c: frame_code};
   end

   rxq_level_decode #(.CODE_W(CODE_W), .LVL_W(BYTE_W),
                      .STEP(BYTE_STEP), .OFFSET(BYTE_OFFSET)) u_byte_lvl (
      .code(held.byte_c), .level(byte_lvl));

   rxq_level_decode #(.CODE_W(CODE_W), .LVL_W(FRAME_W),
                      .STEP(FRAME_STEP), .OFFSET(0)) u_frame_lvl (
      .code(held.frame_c), .level(frame_lvl));

   rxq_frame_tally #(.W(FRAME_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .inc(frame_in), .dec(frame_out),
      .cnt(frames_held));

   rxq_ovf_tracker #(.W(OVF_W)) u_ovf (
      .clk(clk), .rst_n(rst_n), .hit(ovf_hit),
      .seen(ovf_seen), .events(ovf_events));

   assign byte_hit  = fifo_bytes  >= byte_lvl;
   assign frame_hit = frames_held >= frame_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pause_req <= 1'b0;
      else        pause_req <= byte_hit | frame_hit;
   end

   p_byte_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_hit |=> pause_req);
   p_frame_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_hit |=> pause_req);
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_hit && !frame_hit) |=> !pause_req);
   p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req |=> $stable(held));
endmodule

// File: tb/test_rxq_pause_trigger.sv
module test_rxq_pause_trigger;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  byte_code = '0, frame_code = '0;
   logic [11:0] fifo_bytes = '0;
   logic        frame_in = 1'b0, frame_out = 1'b0, ovf_hit = 1'b0;
   logic        pause_req, ovf_seen;
   logic [4:0]  frames_held;
   logic [7:0]  ovf_events;

   int n_chk = 0, n_bad = 0, cycles = 0;
   bit done = 0;

   // reference model state
   logic       m_pause = 0, m_flag = 0;
   logic [2:0] m_bc = 0, m_fc = 0;
   int         m_cnt = 0, m_ovf = 0;

   always #5 clk = ~clk;

   rxq_pause_trigger i_rxq_pause_trigger (
      .clk(clk), .rst_n(rst_n), .byte_code(byte_code), .frame_code(frame_code),
      .fifo_bytes(fifo_bytes), .frame_in(frame_in), .frame_out(frame_out),
      .ovf_hit(ovf_hit), .pause_req(pause_req), .frames_held(frames_held),
      .ovf_seen(ovf_seen), .ovf_events(ovf_events));

   function automatic int blev(input logic [2:0] c);
      return (int'(c) + 1) * 256 - 32;
   endfunction
   function automatic int flev(input logic [2:0] c);
      return (int'(c) + 1) * 2;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // drive at falling edge, let one rising edge pass, model it, compare
   task automatic step(input int fb, input bit fi, input bit fo, input bit ov,
                       input string ptag);
      logic np;
      fifo_bytes = 12'(fb); frame_in = fi; frame_out = fo; ovf_hit = ov;
      @(posedge clk);
      @(negedge clk);
      np = (fb >= blev(m_bc)) || (m_cnt >= flev(m_fc));
      if (!m_pause) begin m_bc = byte_code; m_fc = frame_code; end
      m_pause = np;
      if (fi && !fo && m_cnt < 31) m_cnt++;
      else if (fo && !fi && m_cnt > 0) m_cnt--;
      if (ov) begin m_flag = 1; if (m_ovf < 255) m_ovf++; end
      chk(ptag, int'(pause_req), int'(m_pause));
      chk("R5 frames_held", int'(frames_held), m_cnt);
      chk("R8 ovf_seen", int'(ovf_seen), int'(m_flag));
      chk("R9 ovf_events", int'(ovf_events), m_ovf);
   endtask

   initial begin : watchdog
      while (!done && cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd1977));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 pause_req", int'(pause_req), 0);
      chk("R1 frames_held", int'(frames_held), 0);
      chk("R1 ovf_seen", int'(ovf_seen), 0);
      chk("R1 ovf_events", int'(ovf_events), 0);

      // R2: byte code 0, boundary 223/224
      byte_code = 3'd0; frame_code = 3'd7;
      step(0, 0, 0, 0, "R2 idle");
      step(223, 0, 0, 0, "R2 below 224");
      step(223, 0, 0, 0, "R2 below 224");
      chk("R2 no pause at 223", int'(pause_req), 0);
      step(224, 0, 0, 0, "R2 at 224");
      chk("R2 pause at 224", int'(pause_req), 1);
      step(0, 0, 0, 0, "R4 release");
      chk("R4 dropped", int'(pause_req), 0);

      // R2: byte code 7, boundary 2015/2016
      byte_code = 3'd7;
      step(0, 0, 0, 0, "R7 load code");
      step(2015, 0, 0, 0, "R2 below 2016");
      chk("R2 no pause at 2015", int'(pause_req), 0);
      step(2016, 0, 0, 0, "R2 at 2016");
      chk("R2 pause at 2016", int'(pause_req), 1);
      step(0, 0, 0, 0, "R4 release");

      // R3: frame code 2 -> level 6
      frame_code = 3'd2;
      step(0, 0, 0, 0, "R7 load code");
      for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R3 filling");
      step(0, 0, 0, 0, "R3 five held");
      chk("R3 no pause at 5", int'(pause_req), 0);
      step(0, 1, 0, 0, "R3 sixth frame");
      step(0, 0, 0, 0, "R3 six held");
      chk("R3 pause at 6", int'(pause_req), 1);

      // R7: raise frame code during pause; old level 6 must remain in force
      frame_code = 3'd7;
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R7 code change ignored");
      chk("R7 pause held by old level", int'(pause_req), 1);
      step(0, 0, 1, 0, "R4 below level");
      step(0, 0, 0, 0, "R4 released");
      chk("R4 dropped at 5 frames", int'(pause_req), 0);
      step(0, 1, 0, 0, "R7 new level");
      step(0, 0, 0, 0, "R7 new level");
      chk("R7 no pause at 6 with level 16", int'(pause_req), 0);

      // R5: simultaneous strobes
      step(0, 1, 1, 0, "R5 both");
      chk("R5 unchanged", int'(frames_held), 6);

      // R6: underflow and saturation
      for (int i = 0; i < 9; i++) step(0, 0, 1, 0, "R6 draining");
      chk("R6 floor at 0", int'(frames_held), 0);
      frame_code = 3'd7; byte_code = 3'd7;
      for (int i = 0; i < 40; i++) step(0, 1, 0, 0, "R3 saturating");
      chk("R6 ceiling at 31", int'(frames_held), 31);
      for (int i = 0; i < 31; i++) step(0, 0, 1, 0, "R4 draining");

      // R8/R9: overflow flag and counter saturation
      step(0, 0, 0, 1, "R8 first hit");
      chk("R8 flag set", int'(ovf_seen), 1);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R8 sticky");
      chk("R8 flag kept", int'(ovf_seen), 1);
      for (int i = 0; i < 270; i++) step(0, 0, 0, 1, "R9 counting");
      chk("R9 saturated", int'(ovf_events), 255);

      // mixed random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int fb;
         if ($urandom_range(0, 7) == 0) begin
            byte_code  = 3'($urandom_range(0, 7));
            frame_code = 3'($urandom_range(0, 7));
         end
         fb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 4095))
                                           : int'($urandom_range(150, 600));
         step(fb, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 31) == 0), "R2 R3 R4 R7 random pause");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule